// File: doc/BRIEF.md
# Power-Up Strap Sampling Sequencer

This block manages a set of shared pins that serve first as configuration straps and then as clock outputs. After the supply-good indication asserts, the block keeps every pin driver off for a fixed settling window. During this window, external pull resistors bring each pin to a defined level. On the final cycle of the window, the block takes a synchronized copy of every pin level and stores it as configuration bits. In the same step it switches on all pin drivers, and from then on the pins carry clocks.

The stored bits do not change while supply stays good. The only way to clear them is a loss of supply-good, which sends the block back to its idle state with drivers off. When supply-good returns, the block runs the whole window again. One strap bit chooses how deep the clock generator's down-spread goes, and the block decodes that depth for the generator.

`supply_good` is treated as already synchronous to `clk`. The window length is a parameter counted in reference-clock cycles. The default of 28,636 cycles is about 2 ms at 14.318 MHz.

Top module: `strap_sequencer`

## Requirements
- R1: On any clock edge where `supply_good` is sampled low, the block clears its state. From the next sample onward, `drive_en`, `cfg_bits`, `cfg_valid`, `spread_wide` and `spread_depth_cpct` all read 0.
- R2: While `supply_good` is high and the window has not ended, every bit of `drive_en` stays 0, so every pin driver stays in high impedance.
- R3: At the end of the window, bit i of `cfg_bits` takes the level of `strap_pin[i]` from the input two clock edges before the final edge, after a two-flop synchronizer. A high pin gives 1 and a low pin gives 0.
- R4: `cfg_valid` rises on exactly the WINDOW_CYCLES-th consecutive clock edge at which `supply_good` is sampled high, and never earlier.
- R5: Once `cfg_valid` is high, changes on `strap_pin` have no effect on `cfg_bits` for as long as `supply_good` stays high.
- R6: If `supply_good` falls before or after the window ends, the next rise of `supply_good` restarts a complete window of WINDOW_CYCLES edges.
- R7: `spread_wide` equals `cfg_bits[SPREAD_IDX]`. While `cfg_valid` is high, `spread_depth_cpct` gives the down-spread depth in hundredths of a percent: 125 when `spread_wide` is 0 and 375 when it is 1. While `cfg_valid` is low, `spread_depth_cpct` is 0.
- R8: All bits of `drive_en` rise in the same cycle as `cfg_valid`, and they stay high while `cfg_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| supply_good | input | 1 | Supply above threshold, synchronous to clk |
| strap_pin | input | N_PINS | Levels read back from the shared pins |
| drive_en | output | N_PINS | Per-pin output driver enable, 0 means high impedance |
| cfg_bits | output | N_PINS | Stored strap values |
| cfg_valid | output | 1 | Strap values stored and drivers enabled |
| spread_wide | output | 1 | Strap bit that selects the wide spread |
| spread_depth_cpct | output | 9 | Down-spread depth in 0.01 % units |

## Verification
The bench changes a strap pin two cycles and one cycle before the final edge. A design that captured the raw pin, or that sampled one stage early or late, would store a different value. It removes supply-good in the middle of the window. A counter that kept its partial count would then enable the drivers too early. It also removes supply-good after capture and re-applies it with new straps. A design that held on to the old bits or skipped the window would show this at once. Finally, it changes the pins after capture to show that the stored bits are sticky.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  // Depth of the down-spread in hundredths of a percent.
  function automatic logic [8:0] spread_depth(input logic valid, input logic wide);
    if (!valid) return 9'd0;
    return wide ? 9'd375 : 9'd125;
  endfunction

  // Counter value on which the window closes.
  function automatic int unsigned window_last(input int unsigned cycles);
    return cycles - 1;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [strap_pkg::SYNC_STAGES];

  always_ff @(posedge clk) begin
    stage[0] <= d;
  end

  for (genvar s = 1; s < strap_pkg::SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage[s] <= stage[s-1];
    end
  end

  assign q = stage[strap_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic run,
  input  logic hold,
  output logic capture_pulse
);
  localparam int unsigned CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(strap_pkg::window_last(WINDOW_CYCLES));

  logic [CW-1:0] count;
  logic          at_last;

  assign at_last = (count == LAST);

  always_ff @(posedge clk) begin
    if (!run) begin
      count <= '0;
    end else if (!hold && !at_last) begin
      count <= count + 1'b1;
    end
  end

  assign capture_pulse = run && !hold && at_last;
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             capture,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             valid
);
  always_ff @(posedge clk) begin
    if (clear) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (capture) begin
      q     <= d;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/strap_sequencer.sv
module strap_sequencer #(
  parameter int unsigned N_PINS        = 4,
  parameter int unsigned WINDOW_CYCLES = 28636,
  parameter int unsigned SPREAD_IDX    = 2
) (
  input  logic              clk,
  input  logic              supply_good,
  input  logic [N_PINS-1:0] strap_pin,
  output logic [N_PINS-1:0] drive_en,
  output logic [N_PINS-1:0] cfg_bits,
  output logic              cfg_valid,
  output logic              spread_wide,
  output logic [8:0]        spread_depth_cpct
);
  logic [N_PINS-1:0] sync_q;
  logic              capture_pulse;
  logic              stored;

  strap_sync #(.WIDTH(N_PINS)) u_sync (
    .clk (clk),
    .d   (strap_pin),
    .q   (sync_q)
  );

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk           (clk),
    .run           (supply_good),
    .hold          (stored),
    .capture_pulse (capture_pulse)
  );

  strap_capture #(.WIDTH(N_PINS)) u_capture (
    .clk     (clk),
    .clear   (!supply_good),
    .capture (capture_pulse),
    .d       (sync_q),
    .q       (cfg_bits),
    .valid   (stored)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_drv
    assign drive_en[i] = stored;
  end

  assign cfg_valid         = stored;
  assign spread_wide       = cfg_bits[SPREAD_IDX];
  assign spread_depth_cpct = strap_pkg::spread_depth(stored, cfg_bits[SPREAD_IDX]);
endmodule

// File: rtl/strap_sequencer_chk.sv
module strap_sequencer_chk #(
  parameter int unsigned N_PINS        = 4,
  parameter int unsigned WINDOW_CYCLES = 28636
) (
  input logic              clk,
  input logic              supply_good,
  input logic              capture_pulse,
  input logic [N_PINS-1:0] sync_q,
  input logic [N_PINS-1:0] drive_en,
  input logic [N_PINS-1:0] cfg_bits,
  input logic              cfg_valid
);
  int unsigned good_edges;

  always_ff @(posedge clk) begin
    if (!supply_good) good_edges <= 0;
    else if (good_edges <= WINDOW_CYCLES) good_edges <= good_edges + 1;
  end

  a_r2_drivers_off_in_window: assert property (@(posedge clk) disable iff (!supply_good)
    !cfg_valid |-> (drive_en == '0));

  a_r3_capture_takes_sync: assert property (@(posedge clk) disable iff (!supply_good)
    capture_pulse |=> (cfg_bits == $past(sync_q)));

  a_r4_rise_on_last_edge: assert property (@(posedge clk) disable iff (!supply_good)
    $rose(cfg_valid) |-> (good_edges == WINDOW_CYCLES));

  a_r4_never_early: assert property (@(posedge clk) disable iff (!supply_good)
    (good_edges < WINDOW_CYCLES) |-> !cfg_valid);

  a_r5_bits_sticky: assert property (@(posedge clk) disable iff (!supply_good)
    (cfg_valid && $past(cfg_valid)) |-> $stable(cfg_bits));

  a_r8_enables_follow_pulse: assert property (@(posedge clk) disable iff (!supply_good)
    $rose(cfg_valid) |-> ($past(capture_pulse) && (drive_en == '1)));

  a_r8_enables_stay: assert property (@(posedge clk) disable iff (!supply_good)
    cfg_valid |-> (drive_en == '1));
endmodule

bind strap_sequencer strap_sequencer_chk #(
  .N_PINS(N_PINS), .WINDOW_CYCLES(WINDOW_CYCLES)
) u_chk (
  .clk           (clk),
  .supply_good   (supply_good),
  .capture_pulse (capture_pulse),
  .sync_q        (sync_q),
  .drive_en      (drive_en),
  .cfg_bits      (cfg_bits),
  .cfg_valid     (cfg_valid)
);

// File: tb/strap_sequencer_bench.sv
module strap_sequencer_bench;
  localparam int N = 4;
  localparam int W = 20;
  localparam int SIDX = 2;

  logic         clk = 1'b0;
  logic         supply_good = 1'b0;
  logic [N-1:0] strap_pin = '0;
  logic [N-1:0] drive_en, cfg_bits;
  logic         cfg_valid, spread_wide;
  logic [8:0]   spread_depth_cpct;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int           run_m = 0;
  bit           valid_m = 0;
  logic [N-1:0] cfg_m = '0;
  logic [N-1:0] hist[$];

  always #4 clk = ~clk;

  strap_sequencer #(.N_PINS(N), .WINDOW_CYCLES(W), .SPREAD_IDX(SIDX)) u_strap_sequencer (
    .clk(clk), .supply_good(supply_good), .strap_pin(strap_pin),
    .drive_en(drive_en), .cfg_bits(cfg_bits), .cfg_valid(cfg_valid),
    .spread_wide(spread_wide), .spread_depth_cpct(spread_depth_cpct)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    hist.push_back(strap_pin);
    if (hist.size() > 3) void'(hist.pop_front());
    if (!supply_good) begin
      run_m = 0; valid_m = 0; cfg_m = '0;
    end else if (!valid_m) begin
      run_m++;
      if (run_m == W) begin
        valid_m = 1;
        cfg_m = hist[0];
      end
    end
  end

  // compare each cycle away from the active edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk("R4 cfg_valid", int'(cfg_valid), int'(valid_m));
      chk(valid_m ? "R8 drive_en" : "R2 drive_en", int'(drive_en), valid_m ? (1 << N) - 1 : 0);
      chk("R3 cfg_bits", int'(cfg_bits), int'(cfg_m));
      chk("R7 spread_wide", int'(spread_wide), int'(cfg_m[SIDX]));
      chk("R7 depth", int'(spread_depth_cpct), !valid_m ? 0 : (cfg_m[SIDX] ? 375 : 125));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    // R1: state held clear while supply is absent
    chk("R1 idle valid", int'(cfg_valid), 0);
    chk("R1 idle drive", int'(drive_en), 0);
    chk("R1 idle bits", int'(cfg_bits), 0);

    // first power-up, straps 1011 (spread bit 0)
    strap_pin = 4'b1011;
    supply_good = 1'b1;
    step(W - 1);
    chk("R4 not yet", int'(cfg_valid), 0);
    step(1);
    chk("R4 rise", int'(cfg_valid), 1);
    chk("R3 bits", int'(cfg_bits), 4'b1011);
    chk("R7 narrow", int'(spread_depth_cpct), 125);

    // R5: pins now toggle as clocks; stored bits unchanged
    for (int k = 0; k < 10; k++) begin
      strap_pin = 4'(k * 5);
      step(1);
    end
    chk("R5 sticky", int'(cfg_bits), 4'b1011);

    // R1 and R6: drop after capture, then restart with new straps
    supply_good = 1'b0;
    step(1);
    chk("R1 cleared", int'(cfg_bits), 0);
    chk("R1 drive off", int'(drive_en), 0);
    strap_pin = 4'b0100;
    step(2);
    supply_good = 1'b1;
    step(10);
    // R6: drop in mid-window
    supply_good = 1'b0;
    step(2);
    supply_good = 1'b1;
    step(W - 1);
    chk("R6 full window again", int'(cfg_valid), 0);
    step(1);
    chk("R6 rise after full window", int'(cfg_valid), 1);
    chk("R7 wide", int'(spread_wide), 1);
    chk("R7 wide depth", int'(spread_depth_cpct), 375);

    // R3: pin changes late in the window
    supply_good = 1'b0;
    strap_pin = 4'b0000;
    step(2);
    supply_good = 1'b1;
    step(W - 3);
    strap_pin = 4'b1111;   // driven before edge W-2: captured
    step(1);
    strap_pin = 4'b0001;   // driven before edge W-1: too late
    step(2);
    chk("R3 late change", int'(cfg_bits), 4'b1111);

    step(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule